// File: doc/BRIEF.md
# Cascading Packet Work Dispatcher

This block sits between a descriptor queue and a row of identical packet-processing cores. Each descriptor offered on the input is given to exactly one core. Cores are ranked from index 0 upward. A descriptor always goes to the lowest-ranked core that still has room for work. While traffic is light, the whole load therefore lands on core 0, and the higher cores see nothing. As traffic grows and the lower cores run out of room, work cascades onto further cores until every core shares the load, as a conventional spreader would. The dispatcher needs no software and no configuration to move between the two regimes.

Each core's room for work is tracked by a credit count. The count drops when a descriptor is handed over and rises on a one-cycle completion pulse from that core. For each core the block also raises an idle flag once that core has held no work for a programmable number of cycles. A power controller can use this flag to put the core into a retention sleep state. A core reports whether it is awake. When a descriptor is due for a sleeping core, the block raises a wake request for that core and holds the descriptor until the core is back. No descriptor is ever dropped: when no core can take one, the input is back-pressured.

Top module: `cascade_dispatch`

## Requirements
- R1: Each accepted descriptor appears on the shared dispatch data bus, unchanged, with exactly one `disp_valid` bit set. The transfer completes in the cycle where that bit and the matching `disp_ready` bit are both high. At most one `disp_valid` bit is high in any cycle.
- R2: The target core is the lowest index whose credit count is nonzero. Under light load all work goes to core 0, and higher cores receive nothing.
- R3: After reset, every core's credit count equals CREDITS. An accepted dispatch lowers the count by one, and a `core_done` pulse raises it by one. When both happen in the same cycle, the count does not change. A `core_done` pulse on a core whose count is already CREDITS is ignored.
- R4: When every credit count is zero, `in_ready` is low, all `disp_valid` bits are low, and the descriptor stays pending until a credit returns.
- R5: When the selected core has `disp_ready` low, `in_ready` is low and the descriptor stays presented to that core. It is not redirected to another core.
- R6: `core_idle[k]` rises on the `idle_limit`-th consecutive clock edge at which core k holds all its credits and accepts no dispatch. An `idle_limit` of 0 behaves as 1.
- R7: `core_idle[k]` is low after any edge that accepts a dispatch to core k. It stays low while any of that core's credits are outstanding.
- R8: When the selected core has `core_awake` low, `wake_req` for that core is high while a descriptor is pending. In that state, `disp_valid` and `in_ready` are low until the core reports awake.
- R9: During and directly after reset, `core_idle`, `wake_req` and `disp_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_limit | input | IDLE_W | Quiet edges before a core is flagged idle |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Descriptor accepted this cycle when high with in_valid |
| in_desc | input | DESC_W | Descriptor data |
| disp_valid | output | N_CORES | Per-core dispatch valid, at most one high |
| disp_ready | input | N_CORES | Per-core dispatch ready |
| disp_desc | output | DESC_W | Dispatched descriptor, shared by all cores |
| core_done | input | N_CORES | Per-core completion pulse returning one credit |
| core_awake | input | N_CORES | Per-core awake status from the power controller |
| wake_req | output | N_CORES | Per-core wake request for a pending descriptor |
| core_idle | output | N_CORES | Per-core no-traffic indication |

## Verification
Within a single cycle, a core can both accept a descriptor and return a completion credit. Handling this wrongly either leaks a credit or frees one that does not exist. The bench provokes the case by leaving core 0 with one credit and pulsing its completion input in the same cycle as the next descriptor is taken. The credit should stay at one, so the next descriptor must still go to core 0 and only the one after must spill to core 1. The scoreboard's predicted targets judge this. A completion pulse on an already-full core is also sent before the cores are saturated, and the stall is then expected after exactly CREDITS descriptors per core.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
   function automatic int cnt_w(input int depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/dsp_credit.sv
module dsp_credit #(
   parameter int CREDITS = 4,
   parameter int CW      = dsp_pkg::cnt_w(CREDITS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          give,
   output logic [CW-1:0] count,
   output logic          has_credit,
   output logic          full
);
   generate
      if (CREDITS == 1) begin : g_flag
         logic avail;
         always_ff @(posedge clk) begin
            if (!rst_n)            avail <= 1'b1;
            else if (take && !give) avail <= 1'b0;
            else if (give && !take) avail <= 1'b1;
         end
         assign count      = avail;
         assign has_credit = avail;
         assign full       = avail;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt <= CW'(CREDITS);
            end else if (take && !give) begin
               cnt <= cnt - CW'(1);
            end else if (give && !take && cnt != CW'(CREDITS)) begin
               cnt <= cnt + CW'(1);
            end
         end
         assign count      = cnt;
         assign has_credit = (cnt != '0);
         assign full       = (cnt == CW'(CREDITS));
      end
   endgenerate
endmodule

// File: rtl/dsp_idle_mon.sv
module dsp_idle_mon #(
   parameter int IDLE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              quiet,
   input  logic [IDLE_W-1:0] limit,
   output logic              idle
);
   logic [IDLE_W-1:0] run_len;
   logic [IDLE_W:0]   run_next;

   assign run_next = {1'b0, run_len} + (IDLE_W+1)'(1);

   always_ff @(posedge clk) begin
      if (!rst_n || !quiet) begin
         run_len <= '0;
         idle    <= 1'b0;
      end else begin
         if (run_len != '1) run_len <= run_next[IDLE_W-1:0];
         idle <= idle | (run_next >= {1'b0, limit});
      end
   end
endmodule

// File: rtl/dsp_pick.sv
module dsp_pick #(
   parameter int N_CORES = 4
) (
   input  logic [N_CORES-1:0] avail,
   output logic [N_CORES-1:0] grant,
   output logic               any
);
   logic [N_CORES:0] seen;
   assign seen[0] = 1'b0;

   generate
      for (genvar k = 0; k < N_CORES; k++) begin : g_rank
         assign seen[k+1] = seen[k] | avail[k];
         assign grant[k]  = avail[k] & ~seen[k];
      end
   endgenerate

   assign any = seen[N_CORES];
endmodule

// File: rtl/cascade_dispatch.sv
module cascade_dispatch #(
   parameter int N_CORES = 4,
   parameter int CREDITS = 4,
   parameter int DESC_W  = 16,
   parameter int IDLE_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [IDLE_W-1:0]  idle_limit,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [DESC_W-1:0]  in_desc,
   output logic [N_CORES-1:0] disp_valid,
   input  logic [N_CORES-1:0] disp_ready,
   output logic [DESC_W-1:0]  disp_desc,
   input  logic [N_CORES-1:0] core_done,
   input  logic [N_CORES-1:0] core_awake,
   output logic [N_CORES-1:0] wake_req,
   output logic [N_CORES-1:0] core_idle
);
   localparam int CW = dsp_pkg::cnt_w(CREDITS);

   generate
      if (N_CORES < 1 || CREDITS < 1 || DESC_W < 1 || IDLE_W < 1) begin : g_bad_param
         $error("cascade_dispatch: all sizes must be at least 1");
      end
   endgenerate

   logic [N_CORES-1:0]    has_credit;
   logic [N_CORES-1:0]    full;
   logic [N_CORES-1:0]    grant;
   logic [N_CORES-1:0]    take;
   logic                  any_credit;
   logic [N_CORES*CW-1:0] credit_flat;

   dsp_pick #(.N_CORES(N_CORES)) u_pick (
      .avail (has_credit),
      .grant (grant),
      .any   (any_credit)
   );

   assign disp_valid = {N_CORES{in_valid}} & grant & core_awake;
   assign wake_req   = {N_CORES{in_valid}} & grant & ~core_awake;
   assign take       = disp_valid & disp_ready;
   assign in_ready   = any_credit & |(grant & core_awake & disp_ready);
   assign disp_desc  = in_desc;

   generate
      for (genvar k = 0; k < N_CORES; k++) begin : g_core
         dsp_credit #(.CREDITS(CREDITS), .CW(CW)) u_credit (
            .clk        (clk),
            .rst_n      (rst_n),
            .take       (take[k]),
            .give       (core_done[k]),
            .count      (credit_flat[k*CW +: CW]),
            .has_credit (has_credit[k]),
            .full       (full[k])
         );

         dsp_idle_mon #(.IDLE_W(IDLE_W)) u_idle (
            .clk   (clk),
            .rst_n (rst_n),
            .quiet (full[k] & ~take[k]),
            .limit (idle_limit),
            .idle  (core_idle[k])
         );
      end
   endgenerate
endmodule

// File: rtl/dsp_chk.sv
module dsp_chk #(
   parameter int N_CORES = 4,
   parameter int CREDITS = 4,
   parameter int CW      = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               in_ready,
   input logic [N_CORES-1:0] disp_valid,
   input logic [N_CORES-1:0] disp_ready,
   input logic [N_CORES-1:0] core_done,
   input logic [N_CORES-1:0] core_awake,
   input logic [N_CORES-1:0] wake_req,
   input logic [N_CORES-1:0] core_idle,
   input logic [N_CORES*CW-1:0] credit_flat
);
   logic [N_CORES-1:0] nz;

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(disp_valid)); // R1

   AST_STALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (nz == '0) |-> (!in_ready && disp_valid == '0)); // R4

   AST_ACCEPT_HAS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> $countones(disp_valid & disp_ready) == 1); // R1

   generate
      for (genvar k = 0; k < N_CORES; k++) begin : g_k
         assign nz[k] = (credit_flat[k*CW +: CW] != '0);

         AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            credit_flat[k*CW +: CW] <= CW'(CREDITS)); // R3

         AST_CREDIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            (disp_valid[k] && disp_ready[k] && !core_done[k]) |=>
            credit_flat[k*CW +: CW] == $past(credit_flat[k*CW +: CW]) - CW'(1)); // R3

         AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
            (disp_valid[k] || wake_req[k]) |->
            (nz[k] && (nz & ((N_CORES'(1) << k) - N_CORES'(1))) == '0)); // R2

         AST_WAKE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            wake_req[k] |-> (!disp_valid[k] && !in_ready && !core_awake[k])); // R8

         AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (disp_valid[k] && disp_ready[k]) |=> !core_idle[k]); // R7
      end
   endgenerate
endmodule

bind cascade_dispatch dsp_chk #(
   .N_CORES (N_CORES),
   .CREDITS (CREDITS),
   .CW      (CW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .disp_valid  (disp_valid),
   .disp_ready  (disp_ready),
   .core_done   (core_done),
   .core_awake  (core_awake),
   .wake_req    (wake_req),
   .core_idle   (core_idle),
   .credit_flat (credit_flat)
);

// File: tb/test_cascade_dispatch.sv
module test_cascade_dispatch;
   localparam int CLK_PERIOD = 10;
   localparam int NC   = 4;
   localparam int CR   = 4;
   localparam int DW   = 16;
   localparam int IW   = 8;
   localparam int LIM  = 5;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [IW-1:0] idle_limit;
   logic          in_valid;
   logic          in_ready;
   logic [DW-1:0] in_desc;
   logic [NC-1:0] disp_valid;
   logic [NC-1:0] disp_ready;
   logic [DW-1:0] disp_desc;
   logic [NC-1:0] core_done;
   logic [NC-1:0] core_awake;
   logic [NC-1:0] wake_req;
   logic [NC-1:0] core_idle;

   typedef struct { int core; logic [DW-1:0] data; } exp_t;
   exp_t exp_q[$];
   int   cred[NC];
   int   checks = 0;
   int   fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cascade_dispatch #(.N_CORES(NC), .CREDITS(CR), .DESC_W(DW), .IDLE_W(IW)) i_cascade_dispatch (
      .clk(clk), .rst_n(rst_n), .idle_limit(idle_limit),
      .in_valid(in_valid), .in_ready(in_ready), .in_desc(in_desc),
      .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_desc(disp_desc),
      .core_done(core_done), .core_awake(core_awake),
      .wake_req(wake_req), .core_idle(core_idle)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   function automatic int pick_model();
      for (int k = 0; k < NC; k++) if (cred[k] > 0) return k;
      return -1;
   endfunction

   // monitor: pops a prediction for every completed dispatch
   always @(negedge clk) begin
      if (rst_n) begin
         for (int k = 0; k < NC; k++) begin
            if (disp_valid[k] && disp_ready[k]) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R1 unexpected dispatch", k, 32'hFFFF);
               end else begin
                  exp_t e;
                  e = exp_q.pop_front();
                  chk(e.core == k, "R2 target core", k, e.core);
                  chk(disp_desc == e.data, "R1 descriptor data", disp_desc, e.data);
               end
            end
         end
      end
   end

   // driver: one descriptor, optional completion on a core in the same cycle
   task automatic send(input logic [DW-1:0] data, input int done_core);
      exp_t e;
      e.core = pick_model();
      e.data = data;
      exp_q.push_back(e);
      @(posedge clk) #1;
      in_valid = 1'b1;
      in_desc  = data;
      if (done_core >= 0) core_done[done_core] = 1'b1;
      forever begin
         @(negedge clk);
         if (in_ready) break;
      end
      @(posedge clk) #1;
      in_valid  = 1'b0;
      core_done = '0;
      cred[e.core]--;
      if (done_core >= 0 && cred[done_core] < CR) cred[done_core]++;
   endtask

   task automatic pulse_done(input int k);
      @(posedge clk) #1;
      core_done[k] = 1'b1;
      @(posedge clk) #1;
      core_done[k] = 1'b0;
      if (cred[k] < CR) cred[k]++;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      exp_t e;
      rst_n = 1'b0; idle_limit = IW'(LIM); in_valid = 1'b0; in_desc = '0;
      disp_ready = '1; core_done = '0; core_awake = '1;
      for (int k = 0; k < NC; k++) cred[k] = CR;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(core_idle == '0 && wake_req == '0 && disp_valid == '0, "R9 in reset", {core_idle, wake_req}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(core_idle == '0, "R9 after reset idle", core_idle, 0);

      // R6: idle after exactly LIM quiet edges (one already counted)
      repeat (LIM - 2) @(posedge clk);
      @(negedge clk);
      chk(core_idle == '0, "R6 idle too early", core_idle, 0);
      @(negedge clk);
      chk(core_idle == '1, "R6 idle at limit", core_idle, 4'hF);

      // R2 light load: everything on core 0
      for (int i = 0; i < 6; i++) begin
         send(DW'(16'h100 + i), -1);
         chk(core_idle[0] == 1'b0, "R7 idle cleared by dispatch", core_idle[0], 0);
         pulse_done(0);
         @(negedge clk);
         chk(core_idle[NC-1:1] == '1, "R2 upper cores untouched", core_idle, 4'hE);
      end
      repeat (LIM + 1) @(posedge clk);
      @(negedge clk);
      chk(core_idle[0] == 1'b1, "R6 core 0 idle again", core_idle[0], 1);

      // R3: dispatch and completion in the same cycle on core 0
      for (int i = 0; i < 3; i++) send(DW'(16'h200 + i), -1);
      send(16'h2A0, 0);
      send(16'h2A1, -1);
      send(16'h2A2, -1);
      chk(exp_q.size() == 0, "R3 same-cycle credit", exp_q.size(), 0);
      for (int i = 0; i < CR; i++) pulse_done(0);
      pulse_done(1);

      // R3 completion at full ignored, then R4 saturation
      pulse_done(NC-1);
      for (int i = 0; i < NC*CR; i++) send(DW'(16'h300 + i), -1);
      @(posedge clk) #1;
      in_valid = 1'b1; in_desc = 16'hBEEF;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(!in_ready && disp_valid == '0, "R4 stall with no credit", {in_ready, disp_valid}, 0);
      end
      chk(core_idle == '0, "R7 idle low with credits out", core_idle, 0);
      e.core = 2; e.data = 16'hBEEF; exp_q.push_back(e);
      @(posedge clk) #1; core_done[2] = 1'b1;
      @(posedge clk) #1; core_done[2] = 1'b0;
      @(negedge clk);
      chk(in_ready == 1'b1, "R4 release on credit", in_ready, 1);
      @(posedge clk) #1; in_valid = 1'b0;
      for (int k = 0; k < NC; k++) for (int j = 0; j < CR; j++) pulse_done(k);

      // R5 back-pressure holds on the selected core
      disp_ready[0] = 1'b0;
      @(posedge clk) #1; in_valid = 1'b1; in_desc = 16'h0055;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(!in_ready && disp_valid == 4'b0001, "R5 held on core 0", {in_ready, disp_valid}, 1);
      end
      e.core = 0; e.data = 16'h0055; exp_q.push_back(e);
      @(posedge clk) #1; disp_ready[0] = 1'b1;
      @(posedge clk) #1; in_valid = 1'b0;
      pulse_done(0);

      // R8 wake request for a sleeping core
      repeat (LIM + 1) @(posedge clk);
      core_awake[0] = 1'b0;
      @(posedge clk) #1; in_valid = 1'b1; in_desc = 16'h0077;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(wake_req == 4'b0001 && disp_valid == '0 && !in_ready, "R8 wake and hold",
             {in_ready, disp_valid, wake_req}, 1);
      end
      e.core = 0; e.data = 16'h0077; exp_q.push_back(e);
      @(posedge clk) #1; core_awake[0] = 1'b1;
      @(posedge clk) #1; in_valid = 1'b0;
      @(negedge clk);
      chk(wake_req == '0 && core_idle[0] == 1'b0, "R8 R7 after wake dispatch", {wake_req, core_idle}, 0);
      pulse_done(0);

      repeat (3) @(posedge clk);
      chk(exp_q.size() == 0, "R1 all predictions consumed", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule